// File: doc/BRIEF.md
# Receive Cell Buffer with UTOPIA-Style Read Port

This block sits at the end of a PHY receive path. It collects fixed-length ATM cells byte by byte and holds them in a two-slot buffer. A downstream device, such as a segmentation-and-reassembly engine or a switch port, reads them back over an 8-bit port. The write side sees one byte per valid cycle, and a start flag marks the first byte of each cell. A slot becomes visible to the reader only once its last byte has been written, so the reader never sees a partial cell. If a cell arrives while both slots hold unread data, the whole cell is discarded and a drop counter is bumped.

The read side is driven by an enable from the downstream device. Each granted cycle returns the next byte one clock later. A start-of-cell strobe is registered alongside the first byte of each cell. Two status outputs guide the reader. One is a byte-level empty flag that warns when another read would underflow. The other is a cell-available flag that reports whether a whole cell is waiting that has not yet been started.

Top module: `cell_rx_port`

## Requirements
- R1: After reset, rd_empty is 1, rd_cell_avail is 0, rd_soc is 0, rd_data is 0 and drop_count is 0.
- R2: When rd_enable is 1 and rd_empty is 0 at a rising edge, rd_data carries the next stored byte after that edge. Bytes come out in the order they were written.
- R3: In a cycle with rd_enable low, no byte is consumed: rd_data holds its value and rd_soc is 0.
- R4: rd_soc is 1 for exactly the cycle in which rd_data carries byte 0 of a cell, and 0 for every other byte.
- R5: rd_empty is 1 whenever no complete, not fully read cell is stored. Bytes of a cell still being written never clear it.
- R6: A read requested while rd_empty is 1 returns nothing: rd_data is unchanged, rd_soc stays 0, and the next real read still starts at byte 0 of the next cell.
- R7: rd_cell_avail is 1 while at least one complete cell is stored whose reading has not begun. It falls when the first byte of the last such cell is read.
- R8: A cell is complete on its 53rd byte (CELL_BYTES). Bytes written without in_sop outside a cell, including bytes past the 53rd, are ignored.
- R9: The buffer holds two cells. A cell whose start arrives while both slots hold unread data is dropped whole, never appears at the read port, and raises drop_count by one.
- R10: An in_sop in the middle of a cell restarts that cell in the same slot and discards the partial bytes.
- R11: With DROP_SATURATE=1, drop_count stops at its all-ones value. With DROP_SATURATE=0 it wraps.
- R12: A slot is freed on the cycle the last byte of its cell is read, so a new cell arriving after that is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by write and read sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write byte qualifier |
| in_sop | input | 1 | Marks the written byte as byte 0 of a cell |
| in_data | input | DATA_W | Written byte |
| rd_enable | input | 1 | Read request from the downstream device |
| rd_data | output | DATA_W | Read byte, valid the cycle after a granted request |
| rd_soc | output | 1 | High with byte 0 of a cell on rd_data |
| rd_empty | output | 1 | High when a further read would underflow |
| rd_cell_avail | output | 1 | High when an unstarted complete cell is stored |
| drop_count | output | DROP_W | Number of cells discarded for lack of room |

## Verification
The embedded properties check several invariants on every cycle. The stored-cell count never exceeds the slot count. A refused read moves no pointer and raises no strobe. A start strobe only follows a granted read. Cell-available never coexists with empty. A saturating drop counter never decreases. The bench scenarios cover the points a property cannot reach. They confirm that byte values come out in write order, that completion happens exactly on the 53rd byte, and that a restarted or dropped cell leaves no trace in the data. They also check that a freed slot admits a new cell and that the drop counter saturates at its all-ones value.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;
   // index width that is at least one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   // width of a counter able to hold the value n
   function automatic int unsigned cnt_w(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/cell_rx_store.sv
module cell_rx_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 106,
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];

   initial begin
      assert (DEPTH <= (1 << ADDR_W))
         else $error("cell_rx_store: address too narrow for depth");
   end
endmodule

// File: rtl/cell_rx_wr.sv
module cell_rx_wr #(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CELL_BYTES    = 53,
   parameter int unsigned SLOTS         = 2,
   parameter int unsigned DROP_W        = 8,
   parameter bit          DROP_SATURATE = 1'b1,
   parameter int unsigned IDX_W         = 6,
   parameter int unsigned SLOT_W        = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              slots_full,
   output logic              we,
   output logic [SLOT_W-1:0] w_slot,
   output logic [IDX_W-1:0]  w_idx,
   output logic [DATA_W-1:0] w_data,
   output logic              commit,
   output logic [DROP_W-1:0] drop_count
);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic              active_q;
   logic [IDX_W-1:0]  idx_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DROP_W-1:0] drop_q;
   logic              take_sop, lose_sop, cont;

   always_comb begin
      take_sop = in_valid && in_sop && !slots_full;
      lose_sop = in_valid && in_sop && slots_full;
      cont     = in_valid && !in_sop && active_q;
      we       = take_sop || cont;
      w_idx    = in_sop ? '0 : idx_q;
      w_slot   = slot_q;
      w_data   = in_data;
      commit   = cont && (idx_q == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         slot_q   <= '0;
      end else if (take_sop) begin
         active_q <= 1'b1;
         idx_q    <= IDX_W'(1);
      end else if (lose_sop) begin
         active_q <= 1'b0;
         idx_q    <= '0;
      end else if (cont) begin
         if (idx_q == LAST_IDX) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            slot_q   <= (slot_q == LAST_SLOT) ? '0 : slot_q + SLOT_W'(1);
         end else begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   generate
      if (DROP_SATURATE) begin : g_drop_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                       drop_q <= '0;
            else if (lose_sop && drop_q != '1) drop_q <= drop_q + DROP_W'(1);
         end
         AST_DROP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
            ##1 drop_q >= $past(drop_q)); // R11
      end else begin : g_drop_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)        drop_q <= '0;
            else if (lose_sop) drop_q <= drop_q + DROP_W'(1);
         end
      end
   endgenerate

   assign drop_count = drop_q;

   AST_COMMIT_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !slots_full); // R9
   AST_IDX_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX); // R8
endmodule

// File: rtl/cell_rx_rd.sv
module cell_rx_rd #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CELL_BYTES = 53,
   parameter int unsigned SLOTS      = 2,
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned SLOT_W     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              have_cell,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [SLOT_W-1:0] r_slot,
   output logic [IDX_W-1:0]  r_idx,
   output logic [DATA_W-1:0] out_data,
   output logic              out_soc,
   output logic              finish,
   output logic              mid_cell
);
   localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   logic grant;

   always_comb begin
      grant    = rd_req && have_cell;
      finish   = grant && (r_idx == LAST_IDX);
      mid_cell = (r_idx != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_slot   <= '0;
         r_idx    <= '0;
         out_data <= '0;
         out_soc  <= 1'b0;
      end else begin
         out_soc <= grant && (r_idx == '0);
         if (grant) begin
            out_data <= mem_rdata;
            if (r_idx == LAST_IDX) begin
               r_idx  <= '0;
               r_slot <= (r_slot == LAST_SLOT) ? '0 : r_slot + SLOT_W'(1);
            end else begin
               r_idx <= r_idx + IDX_W'(1);
            end
         end
      end
   end

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !have_cell) |=> ($stable(r_idx) && $stable(r_slot) && !out_soc)); // R6
endmodule

// File: rtl/cell_rx_port.sv
module cell_rx_port
   import cell_rx_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned CELL_BYTES    = 53,
   parameter int unsigned SLOTS         = 2,
   parameter int unsigned DROP_W        = 8,
   parameter bit          DROP_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DATA_W-1:0] in_data,
   input  logic              rd_enable,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_soc,
   output logic              rd_empty,
   output logic              rd_cell_avail,
   output logic [DROP_W-1:0] drop_count
);
   localparam int unsigned IDX_W  = idx_w(CELL_BYTES);
   localparam int unsigned SLOT_W = idx_w(SLOTS);
   localparam int unsigned CNT_W  = cnt_w(SLOTS);
   localparam int unsigned DEPTH  = SLOTS * CELL_BYTES;
   localparam int unsigned ADDR_W = idx_w(DEPTH);

   generate
      if (CELL_BYTES < 2) begin : g_bad_cell
         $error("cell_rx_port: CELL_BYTES must be at least 2");
      end
      if (SLOTS < 1) begin : g_bad_slots
         $error("cell_rx_port: SLOTS must be at least 1");
      end
      if (DATA_W < 1 || DROP_W < 1) begin : g_bad_width
         $error("cell_rx_port: widths must be positive");
      end
   endgenerate

   logic              we, commit, finish, mid;
   logic [SLOT_W-1:0] w_slot, r_slot;
   logic [IDX_W-1:0]  w_idx, r_idx;
   logic [DATA_W-1:0] w_data, mem_rdata;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [CNT_W-1:0]  ready_q;
   logic              full;

   assign full  = (ready_q == CNT_W'(SLOTS));
   assign waddr = ADDR_W'(w_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(w_idx);
   assign raddr = ADDR_W'(r_slot) * ADDR_W'(CELL_BYTES) + ADDR_W'(r_idx);

   cell_rx_wr #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS), .DROP_W(DROP_W),
      .DROP_SATURATE(DROP_SATURATE), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
   ) wr_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .slots_full(full), .we(we), .w_slot(w_slot),
      .w_idx(w_idx), .w_data(w_data), .commit(commit), .drop_count(drop_count)
   );

   cell_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) store_i (
      .clk(clk), .we(we), .waddr(waddr), .wdata(w_data),
      .raddr(raddr), .rdata(mem_rdata)
   );

   cell_rx_rd #(
      .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES), .SLOTS(SLOTS),
      .IDX_W(IDX_W), .SLOT_W(SLOT_W)
   ) rd_i (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_enable), .have_cell(!rd_empty),
      .mem_rdata(mem_rdata), .r_slot(r_slot), .r_idx(r_idx),
      .out_data(rd_data), .out_soc(rd_soc), .finish(finish), .mid_cell(mid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= '0;
      else        ready_q <= ready_q + CNT_W'(commit) - CNT_W'(finish);
   end

   assign rd_empty      = (ready_q == '0);
   assign rd_cell_avail = (ready_q > CNT_W'(mid));

   AST_CELLS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q <= CNT_W'(SLOTS)); // R9
   AST_AVAIL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cell_avail |-> !rd_empty); // R7
   AST_SOC_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_soc |-> $past(rd_enable && !rd_empty)); // R4
endmodule

// File: tb/cell_rx_port_tb.sv
module cell_rx_port_tb_top;
   localparam int unsigned DW = 8;
   localparam int unsigned CB = 53;
   localparam int unsigned OW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sop = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          rd_enable = 1'b0;
   logic [DW-1:0] rd_data;
   logic          rd_soc, rd_empty, rd_cell_avail;
   logic [OW-1:0] drop_count;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cell_rx_port #(.DATA_W(DW), .CELL_BYTES(CB), .SLOTS(2), .DROP_W(OW),
                  .DROP_SATURATE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .rd_enable(rd_enable), .rd_data(rd_data),
      .rd_soc(rd_soc), .rd_empty(rd_empty), .rd_cell_avail(rd_cell_avail),
      .drop_count(drop_count)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [DW-1:0] d, input logic sop);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_sop = sop;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
   endtask

   task automatic send_bytes(input int base, input int n, input bit first_sop);
      for (int i = 0; i < n; i++) put_byte(DW'(base + i), first_sop && (i == 0));
   endtask

   task automatic read_one(output int d, output int s);
      @(negedge clk);
      rd_enable = 1'b1;
      @(negedge clk);
      rd_enable = 1'b0;
      d = int'(rd_data);
      s = int'(rd_soc);
   endtask

   // read a full cell, checking values, strobe and the availability after byte 0
   task automatic read_cell(input int base, input int avail_after_first);
      int d, s;
      for (int i = 0; i < CB; i++) begin
         read_one(d, s);
         chk("R2 byte value", d, (base + i) & 255);
         chk("R4 soc on byte 0 only", s, (i == 0) ? 1 : 0);
         if (i == 0) chk("R7 avail after first byte", int'(rd_cell_avail), avail_after_first);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int d, s, hold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 empty", int'(rd_empty), 1);
      chk("R1 avail", int'(rd_cell_avail), 0);
      chk("R1 soc", int'(rd_soc), 0);
      chk("R1 data", int'(rd_data), 0);
      chk("R1 drop", int'(drop_count), 0);

      // R5 partial cell invisible, then R10 restart mid-cell
      send_bytes(8'hA0, 20, 1'b1);
      chk("R5 partial empty", int'(rd_empty), 1);
      send_bytes(8'h10, CB - 1, 1'b1);
      chk("R8 52 bytes not complete", int'(rd_empty), 1);
      chk("R7 no avail before complete", int'(rd_cell_avail), 0);
      put_byte(DW'(8'h10 + CB - 1), 1'b0);
      chk("R8 complete on 53rd", int'(rd_empty), 0);
      chk("R7 avail on complete", int'(rd_cell_avail), 1);

      // R3 idle cycles consume nothing
      hold = int'(rd_data);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk("R3 data held", int'(rd_data), hold);
         chk("R3 soc low", int'(rd_soc), 0);
      end

      read_cell(8'h10, 0);                        // R10 restarted bytes only
      chk("R5 empty after drain", int'(rd_empty), 1);

      // R6 read while empty
      read_one(d, s);
      chk("R6 data unchanged", d, (8'h10 + CB - 1) & 255);
      chk("R6 soc low", s, 0);

      // R8 extras ignored, R9 third cell dropped
      send_bytes(8'h30, CB, 1'b1);
      send_bytes(8'hE0, 5, 1'b0);
      send_bytes(8'h60, CB, 1'b1);
      chk("R9 two held", int'(rd_cell_avail), 1);
      send_bytes(8'h90, CB, 1'b1);
      chk("R9 drop counted", int'(drop_count), 1);

      read_cell(8'h30, 1);                        // second cell still waiting
      // R12 slot freed: new cell accepted while B held
      send_bytes(8'hC0, CB, 1'b1);
      chk("R12 no new drop", int'(drop_count), 1);
      read_cell(8'h60, 1);                        // R8 extras and R9 drop absent
      read_cell(8'hC0, 0);
      chk("R5 empty at end", int'(rd_empty), 1);

      // sweep of bases through both slots repeatedly
      for (int k = 0; k < 6; k++) begin
         send_bytes(k * 37, CB, 1'b1);
         send_bytes(k * 37 + 100, CB, 1'b1);
         read_cell(k * 37, 1);
         read_cell(k * 37 + 100, 0);
      end
      chk("R2 sweep leaves empty", int'(rd_empty), 1);

      // R11 saturation of the drop counter
      send_bytes(8'h01, CB, 1'b1);
      send_bytes(8'h02, CB, 1'b1);
      for (int i = 0; i < 20; i++) begin
         put_byte(DW'(i), 1'b1);
         chk("R11 drop count", int'(drop_count), (1 + i + 1 > 15) ? 15 : 1 + i + 1);
      end
      read_cell(8'h01, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule